// File: doc/BRIEF.md
# Serial Sticky Status Readout Register

This block collects one-cycle event pulses, such as sweep and trigger activity, into a bank of sticky flags. A host controller reads them out over a two-wire serial link: a serial clock that the host drives and a data line that the block drives. There is no chip select and no frame strobe. Every readout is exactly as many clock pulses as there are status bits. The data line is valid before each clock pulse. The host samples it and then pulses the clock, and each pulse moves the line to the next bit, least significant first.

The flags are double-buffered. A transfer copies the sticky flags into a holding register, clears the flags, and reloads the output shifter from the copy. A transfer happens when the last pulse of a frame arrives, or when a separate control shift register is rewritten, which is signalled by a one-cycle strobe. The data a host reads in a frame was therefore captured at the end of the previous frame. The strobe also resets the pulse counter, so host and block can regain frame alignment after a partial read.

The serial clock comes from outside the system clock domain. It passes through a two-stage synchronizer, and the block acts on its rising edges.

Top module: `sticky_status_readout`

## Requirements
- R1: After reset, the sticky flags, holding register, output shifter and pulse counter are all zero, so `sdo_o` is 0 and the first frame read returns 0.
- R2: A pulse on bit k of `event_i` sets sticky flag k. It stays set until the next transfer, and flags from separate pulses accumulate as a bitwise OR.
- R3: On the 16th rising edge of `sclk_i` in a frame, the flags are copied into the holding register and then cleared. The shifter is reloaded from that copy, so the next frame returns the events gathered before that edge and the frame after it returns only newer events.
- R4: A one-cycle pulse on `ctrl_wr_i` causes the same transfer and reload, and it resets the pulse counter to zero. After a partial frame, a strobe followed by 16 pulses reads the full snapshot.
- R5: Bit 0 of the snapshot is on `sdo_o` before the first pulse. Each rising edge of `sclk_i` presents the next higher bit.
- R6: An event that arrives in the same cycle as a transfer is not lost. It stays in the sticky flags and appears in the snapshot of the following transfer.
- R7: Between rising edges of `sclk_i`, `sdo_o` keeps its level, including after the last pulse of a frame, even while new events arrive.
- R8: `sclk_i` is synchronized through two flops. Holding it high for many system clocks advances the output by exactly one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| event_i | input | 16 | One-cycle event pulses, one per status bit |
| ctrl_wr_i | input | 1 | Strobe: the control shift register was rewritten |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| sdo_o | output | 1 | Serial status data, least significant bit first |

## Verification
The bench checks the stale first frame after reset and the one-frame lag of every snapshot. A design that reloaded the shifter late, or failed to clear the flags, would return the wrong frame or repeat old events. It starts a frame part way through, and then strobes `ctrl_wr_i` to realign. A counter that the strobe did not reset would end the next frame early and shift out a rotated value. It also fires an event in the same cycle as a transfer, which a design that clears after OR-ing would drop. It holds the serial clock high for a long time to expose level-triggered shifting, and it watches the data line stay steady between frames while events arrive.

// File: rtl/ssr_pkg.sv
// Shared constants for the serial sticky status readout.
// Assumes nothing beyond a 16-bit default status width.
package ssr_pkg;
    localparam int unsigned DEFAULT_STATUS_W = 16;
endpackage

// File: rtl/ssr_sclk_sync.sv
// Two-flop synchronizer for the host serial clock with rising-edge detect.
// Assumes sclk_i is asynchronous and stays at each level for two or more clk cycles.
module ssr_sclk_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    output logic rise_o
);
    logic [2:0] sync_q;

    // Shift the raw clock through two sync stages plus an edge-history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], sclk_i};
    end

    assign rise_o = sync_q[1] & ~sync_q[2];

    assert_single_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/ssr_event_bank.sv
// Sticky primary flags plus the holding register they are copied into on transfer.
// Assumes event_i bits are one-cycle pulses in the clk domain.
module ssr_event_bank #(
    parameter int unsigned STATUS_W = ssr_pkg::DEFAULT_STATUS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] event_i,
    input  logic                xfer_i,
    output logic [STATUS_W-1:0] hold_o
);
    logic [STATUS_W-1:0] flags_q;

    // Clear the copied flags on transfer, then OR in this cycle's events.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (xfer_i ? '0 : flags_q) | event_i;
    end

    // Capture the flags into the holding register on transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_o <= '0;
        else if (xfer_i) hold_o <= flags_q;
    end

    assert_event_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i != '0) |=> ((flags_q & $past(event_i)) == $past(event_i)));

    assert_flags_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && event_i == '0) |=> (flags_q == '0));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/ssr_shifter.sv
// LSB-first output shifter and pulse counter within a frame.
// Assumes serial rises are at least two clk cycles apart.
module ssr_shifter #(
    parameter int unsigned STATUS_W = ssr_pkg::DEFAULT_STATUS_W,
    localparam int unsigned CNT_W   = $clog2(STATUS_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise_i,
    input  logic                ctrl_wr_i,
    input  logic                xfer_i,
    input  logic [STATUS_W-1:0] hold_i,
    output logic                last_o,
    output logic                sdo_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STATUS_W - 1);

    logic [CNT_W-1:0]    cnt_q;
    logic [STATUS_W-1:0] shift_q;
    logic                load_q;

    assign last_o = rise_i && (cnt_q == LAST_CNT);

    // Count pulses in the frame; a control rewrite realigns to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_wr_i) cnt_q <= '0;
        else if (last_o)         cnt_q <= '0;
        else if (rise_i)         cnt_q <= cnt_q + 1'b1;
    end

    // Request a reload the cycle after a transfer, once the holding register has updated.
    always_ff @(posedge clk) begin
        if (!rst_n) load_q <= 1'b0;
        else        load_q <= xfer_i;
    end

    // Reload from the holding register, or move to the next bit on each rise.
    always_ff @(posedge clk) begin
        if (!rst_n)      shift_q <= '0;
        else if (load_q) shift_q <= hold_i;
        else if (rise_i) shift_q <= {1'b0, shift_q[STATUS_W-1:1]};
    end

    assign sdo_o = shift_q[0];

    assert_counter_realign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_i |=> (cnt_q == '0));

    assert_hold_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_i && !load_q) |=> $stable(sdo_o));
endmodule

// File: rtl/sticky_status_readout.sv
// Top level: sticky event capture, double buffering and 16-pulse serial readout.
// Assumes the host samples sdo_o and then pulses sclk_i, with no chip select.
module sticky_status_readout #(
    parameter int unsigned STATUS_W = ssr_pkg::DEFAULT_STATUS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] event_i,
    input  logic                ctrl_wr_i,
    input  logic                sclk_i,
    output logic                sdo_o
);
    logic                rise;
    logic                last;
    logic                xfer;
    logic [STATUS_W-1:0] hold;

    assign xfer = ctrl_wr_i | last;

    ssr_sclk_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk_i),
        .rise_o (rise)
    );

    ssr_event_bank #(.STATUS_W(STATUS_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (event_i),
        .xfer_i  (xfer),
        .hold_o  (hold)
    );

    ssr_shifter #(.STATUS_W(STATUS_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .ctrl_wr_i (ctrl_wr_i),
        .xfer_i    (xfer),
        .hold_i    (hold),
        .last_o    (last),
        .sdo_o     (sdo_o)
    );
endmodule

// File: tb/sim_sticky_status_readout.sv
module sim_sticky_status_readout;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 0;
    logic         rst_n = 0;
    logic [W-1:0] event_i = '0;
    logic         ctrl_wr_i = 0;
    logic         sclk_i = 0;
    logic         sdo_o;
    int           n_checks = 0;
    int           n_fail = 0;

    sticky_status_readout #(.STATUS_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .event_i(event_i),
        .ctrl_wr_i(ctrl_wr_i), .sclk_i(sclk_i), .sdo_o(sdo_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ev(input logic [W-1:0] v);
        @(negedge clk); event_i = v;
        @(negedge clk); event_i = '0;
    endtask

    task automatic sclk_pulse(input int high_cycles);
        sclk_i = 1; cyc(high_cycles);
        sclk_i = 0; cyc(5);
    endtask

    task automatic read_bits(input int n, output logic [W-1:0] v);
        v = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            v[i] = sdo_o;
            sclk_pulse(5);
        end
    endtask

    task automatic ctrl_strobe(input logic [W-1:0] ev);
        @(negedge clk); ctrl_wr_i = 1; event_i = ev;
        @(negedge clk); ctrl_wr_i = 0; event_i = '0;
        cyc(3);
    endtask

    task automatic t_reset;
        logic [W-1:0] v;
        chk("R1 sdo after reset", {15'b0, sdo_o}, 16'h0);
        pulse_ev(16'h1234);
        read_bits(16, v);
        chk("R1 first frame stale zero", v, 16'h0);
    endtask

    task automatic t_lag;
        logic [W-1:0] v;
        read_bits(16, v);
        chk("R3 snapshot from previous frame", v, 16'h1234);
        read_bits(16, v);
        chk("R3 flags cleared after transfer", v, 16'h0);
    endtask

    task automatic t_sticky;
        logic [W-1:0] v;
        pulse_ev(16'h0001); cyc(3);
        pulse_ev(16'h8000); cyc(3);
        pulse_ev(16'h0001);
        read_bits(16, v);
        chk("R2 stale frame", v, 16'h0);
        read_bits(16, v);
        chk("R2 R5 sticky OR lsb first", v, 16'h8001);
    endtask

    task automatic t_realign;
        logic [W-1:0] v;
        pulse_ev(16'h0A0A);
        read_bits(5, v);
        pulse_ev(16'h5500);
        ctrl_strobe('0);
        chk("R4 bit0 after strobe", {15'b0, sdo_o}, 16'h0);
        read_bits(16, v);
        chk("R4 realigned frame", v, 16'h5F0A);
        read_bits(16, v);
        chk("R4 next frame empty", v, 16'h0);
    endtask

    task automatic t_same_cycle;
        logic [W-1:0] v;
        pulse_ev(16'h0003);
        ctrl_strobe(16'h0100);
        read_bits(16, v);
        chk("R6 strobe snapshot", v, 16'h0003);
        read_bits(16, v);
        chk("R6 event kept", v, 16'h0100);
    endtask

    task automatic t_hold;
        logic [W-1:0] v;
        pulse_ev(16'h0001);
        read_bits(16, v);
        cyc(3);
        chk("R7 sdo after last pulse", {15'b0, sdo_o}, 16'h1);
        pulse_ev(16'hFFFE);
        cyc(20);
        chk("R7 sdo held", {15'b0, sdo_o}, 16'h1);
        read_bits(16, v);
        chk("R7 held snapshot", v, 16'h0001);
        read_bits(16, v);
        chk("R7 later events", v, 16'hFFFE);
    endtask

    task automatic t_long_high;
        logic [W-1:0] v;
        pulse_ev(16'h0006);
        ctrl_strobe('0);
        chk("R8 bit0", {15'b0, sdo_o}, 16'h0);
        sclk_pulse(40);
        chk("R8 one bit per long pulse", {15'b0, sdo_o}, 16'h1);
        sclk_pulse(5);
        chk("R8 bit2", {15'b0, sdo_o}, 16'h1);
        sclk_pulse(5);
        chk("R5 bit3", {15'b0, sdo_o}, 16'h0);
        ctrl_strobe('0);
        read_bits(16, v);
        chk("R4 empty after strobe", v, 16'h0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(2);
        t_reset();
        t_lag();
        t_sticky();
        t_realign();
        t_same_cycle();
        t_hold();
        t_long_high();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule